// File: doc/BRIEF.md
# Dual Programmable Interval Timer

This peripheral holds two independent 32-bit timer/counters behind a small word-addressed register port. Each timer owns three registers: a control/status word, a reload value and a live counter. Software chooses the direction of counting and whether the counter restarts from the reload value after it rolls over. It can hold the counter at the reload value through a preload bit, and it can route the rollover flag to a shared interrupt line.

Typical use pairs the two timers. One runs as a down counter with interrupts, either single-shot or periodic, and serves as the event source. The other runs as a free counting-up 32-bit counter with no interrupt and serves as the time base. An interrupt is acknowledged by reading the control/status word and writing that value straight back, because the flag bit clears when a one is written to it.

Top module: `dual_timer`

## Requirements
- R1: After reset every register of both timers reads zero and `irq` is low.
- R2: Timer 0 sits at byte offsets 0x00 (control/status), 0x04 (reload), 0x08 (counter), and timer 1 at 0x10, 0x14, 0x18. Control/status bits: 0 mode, 1 count-down, 2 generate-out, 3 capture, 4 auto-reload, 5 preload, 6 interrupt enable, 7 run, 8 rollover flag, 9 PWM, 10 enable-all. Every bit except the flag reads back exactly as last written.
- R3: While the preload bit is set, the counter copies the reload register on every clock and does not count.
- R4: With run set and preload clear, the counter moves by one per clock: downward when bit 1 is 1, upward when it is 0.
- R5: A rollover is a run cycle (run set, preload clear) in which a down counter holds 0 or an up counter holds 0xFFFFFFFF. A rollover sets the flag.
- R6: On a rollover with auto-reload clear, the counter keeps its value and the run bit clears.
- R7: On a rollover with auto-reload set, the counter takes the reload value and the run bit stays set.
- R8: Writing 1 to flag bit 8 clears the flag and writing 0 leaves it, so writing back the word just read acknowledges a pending interrupt. A rollover in the same cycle as the clearing write wins.
- R9: `irq` is high exactly when some timer has both its flag and its interrupt enable set.
- R10: A timer counting up with auto-reload set and a reload value of zero wraps modulo 2^32 (0xFFFFFFFF is followed by 0).
- R11: Offsets 0x0C, 0x1C and any offset not a multiple of 4 read zero, and writes to them change nothing. The counter registers ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 5 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, a combinational function of `bus_addr` and register state |
| irq | output | 1 | OR over both timers of flag AND interrupt enable |

## Verification
A register write takes effect at the clock edge that samples it. Read data follows the address combinationally, so every read is taken one nanosecond after the address settles, between clock edges. The counter first moves on the edge after the write that sets the run bit. A rollover found on edge N shows in the flag, the run bit and `irq` just after edge N. The bench drives on the falling edge, then samples one nanosecond after each rising edge, and counts edges from the write edge to reach the cycle that each expected value belongs to.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int CSR_W  = 11;
  localparam int B_MODE = 0;
  localparam int B_DOWN = 1;
  localparam int B_GEN  = 2;
  localparam int B_CAPT = 3;
  localparam int B_ARLD = 4;
  localparam int B_LOAD = 5;
  localparam int B_IE   = 6;
  localparam int B_RUN  = 7;
  localparam int B_FLAG = 8;
  localparam int B_PWM  = 9;
  localparam int B_ALL  = 10;

  typedef enum logic [1:0] {
    RSEL_CSR  = 2'd0,
    RSEL_LOAD = 2'd1,
    RSEL_CNT  = 2'd2,
    RSEL_NONE = 2'd3
  } rsel_e;
endpackage

// File: rtl/dtmr_channel.sv
module dtmr_channel
  import dtmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_csr,
  input  logic              wr_load,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] csr_o,
  output logic [DATA_W-1:0] load_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
  localparam logic [DATA_W-1:0] ZERO = '0;
  localparam logic [DATA_W-1:0] MAXV = '1;

  logic [CSR_W-1:0]  csr_q, csr_d;
  logic [DATA_W-1:0] load_q, load_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              at_end, roll;
  logic              csr_we, cnt_we;

  // next-state logic
  always_comb begin
    csr_d  = csr_q;
    load_d = load_q;
    cnt_d  = cnt_q;
    at_end = csr_q[B_DOWN] ? (cnt_q == ZERO) : (cnt_q == MAXV);
    roll   = csr_q[B_RUN] && !csr_q[B_LOAD] && at_end;

    if (csr_q[B_LOAD]) begin
      cnt_d = load_q;
    end else if (csr_q[B_RUN]) begin
      if (at_end) begin
        if (csr_q[B_ARLD]) cnt_d = load_q;
      end else begin
        cnt_d = csr_q[B_DOWN] ? (cnt_q - ONE) : (cnt_q + ONE);
      end
    end

    if (wr_csr) begin
      csr_d         = wdata[CSR_W-1:0];
      csr_d[B_FLAG] = csr_q[B_FLAG] & ~wdata[B_FLAG];
    end
    if (roll) begin
      csr_d[B_FLAG] = 1'b1;
      if (!csr_q[B_ARLD] && !wr_csr) csr_d[B_RUN] = 1'b0;
    end

    if (wr_load) load_d = wdata;
  end

  assign csr_we = wr_csr | roll;
  assign cnt_we = csr_q[B_LOAD] | csr_q[B_RUN];

  // registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q  <= '0;
      load_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (csr_we)  csr_q  <= csr_d;
      if (wr_load) load_q <= load_d;
      if (cnt_we)  cnt_q  <= cnt_d;
    end
  end

  assign csr_o  = {{(DATA_W-CSR_W){1'b0}}, csr_q};
  assign load_o = load_q;
  assign cnt_o  = cnt_q;
  assign irq_o  = csr_q[B_FLAG] & csr_q[B_IE];

  assert_preload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    csr_q[B_LOAD] |=> cnt_q == $past(load_q));

  assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_q[B_RUN] && !csr_q[B_LOAD] && !csr_q[B_DOWN] && cnt_q != MAXV)
      |=> cnt_q == $past(cnt_q) + ONE);

  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_q[B_RUN] && !csr_q[B_LOAD] && csr_q[B_DOWN] && cnt_q != ZERO)
      |=> cnt_q == $past(cnt_q) - ONE);

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_q[B_RUN] && !csr_q[B_LOAD] &&
     ((csr_q[B_DOWN] && cnt_q == ZERO) || (!csr_q[B_DOWN] && cnt_q == MAXV)))
      |=> csr_q[B_FLAG]);

  assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_q[B_RUN] && !csr_q[B_LOAD] && !csr_q[B_ARLD] && !wr_csr &&
     ((csr_q[B_DOWN] && cnt_q == ZERO) || (!csr_q[B_DOWN] && cnt_q == MAXV)))
      |=> (!csr_q[B_RUN] && $stable(cnt_q)));

  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_q[B_RUN] && !csr_q[B_LOAD] && csr_q[B_ARLD] && !wr_csr &&
     ((csr_q[B_DOWN] && cnt_q == ZERO) || (!csr_q[B_DOWN] && cnt_q == MAXV)))
      |=> (csr_q[B_RUN] && cnt_q == $past(load_q)));
endmodule

// File: rtl/dtmr_regmux.sv
module dtmr_regmux
  import dtmr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_TMR = 2,
  parameter int ADDR_W  = 5
) (
  input  logic                            bus_wr,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [NUM_TMR-1:0][DATA_W-1:0]  csr_v,
  input  logic [NUM_TMR-1:0][DATA_W-1:0]  load_v,
  input  logic [NUM_TMR-1:0][DATA_W-1:0]  cnt_v,
  output logic [NUM_TMR-1:0]              wr_csr,
  output logic [NUM_TMR-1:0]              wr_load,
  output logic [DATA_W-1:0]               rdata
);
  localparam int SEL_W = ADDR_W - 4;

  logic             word_ok;
  logic [SEL_W-1:0] sel;
  rsel_e            idx;

  assign word_ok = (bus_addr[1:0] == 2'b00);
  assign sel     = bus_addr[ADDR_W-1:4];
  assign idx     = rsel_e'(bus_addr[3:2]);

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_dec
    assign wr_csr[i]  = bus_wr && word_ok && (sel == SEL_W'(i)) && (idx == RSEL_CSR);
    assign wr_load[i] = bus_wr && word_ok && (sel == SEL_W'(i)) && (idx == RSEL_LOAD);
  end

  always_comb begin
    rdata = '0;
    if (word_ok && (int'(sel) < NUM_TMR)) begin
      case (idx)
        RSEL_CSR:  rdata = csr_v[sel];
        RSEL_LOAD: rdata = load_v[sel];
        RSEL_CNT:  rdata = cnt_v[sel];
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dtmr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_TMR = 2,
  localparam int ADDR_W = 4 + $clog2(NUM_TMR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [1:0]                       rst_sync_q;
  logic                             rst_core_n;
  logic [NUM_TMR-1:0][DATA_W-1:0]   csr_v, load_v, cnt_v;
  logic [NUM_TMR-1:0]               wr_csr, wr_load, irq_v;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  dtmr_regmux #(
    .DATA_W (DATA_W),
    .NUM_TMR(NUM_TMR),
    .ADDR_W (ADDR_W)
  ) u_regmux (
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .csr_v   (csr_v),
    .load_v  (load_v),
    .cnt_v   (cnt_v),
    .wr_csr  (wr_csr),
    .wr_load (wr_load),
    .rdata   (bus_rdata)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    dtmr_channel #(.DATA_W(DATA_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .wr_csr (wr_csr[i]),
      .wr_load(wr_load[i]),
      .wdata  (bus_wdata),
      .csr_o  (csr_v[i]),
      .load_o (load_v[i]),
      .cnt_o  (cnt_v[i]),
      .irq_o  (irq_v[i])
    );
  end

  assign irq = |irq_v;

  logic [NUM_TMR-1:0] flag_v;
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_flag
    assign flag_v[i] = csr_v[i][B_FLAG];
  end

  assert_irq_has_flag_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq |-> (flag_v != '0));

  assert_undef_write_R11: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_wr && (bus_addr[1:0] != 2'b00 || bus_addr[3:2] == 2'b11))
      |=> ($stable(load_v) && $stable(flag_v)));
endmodule

// File: tb/dual_timer_bench.sv
module dual_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_timer u_dual_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    foreach (v[k]) v[k] = 1'b0;
    for (int a = 0; a < 32; a += 4) begin
      peek(5'(a), v);
      chk("R1 register zero after reset", v, 32'h0);
      if (a == 12) tick(1);
    end
    chk("R1 irq low after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_probe;
    logic [31:0] v;
    wr(5'h00, 32'h1);
    peek(5'h00, v); chk("R2 mode bit read back", v, 32'h1);
    wr(5'h00, 32'h61F);
    peek(5'h00, v); chk("R2 idle bits read back", v, 32'h61F);
    wr(5'h00, 32'h0);
  endtask

  task automatic t_preload;
    logic [31:0] v;
    wr(5'h04, 32'd5);
    wr(5'h00, 32'hA0);
    tick(3);
    peek(5'h08, v); chk("R3 preload holds while running", v, 32'd5);
    wr(5'h00, 32'h80);
    tick(4);
    peek(5'h08, v); chk("R4 up count", v, 32'd9);
    wr(5'h00, 32'h0);
  endtask

  task automatic t_oneshot_down;
    logic [31:0] v;
    wr(5'h04, 32'd3);
    wr(5'h00, 32'h20);
    wr(5'h00, 32'hC2);
    tick(2);
    peek(5'h08, v); chk("R4 down count", v, 32'd1);
    tick(1);
    peek(5'h08, v); chk("R4 reaches zero", v, 32'd0);
    chk("R5 no flag before rollover", {31'b0, irq}, 32'h0);
    tick(1);
    peek(5'h00, v); chk("R6 run clears, R5 flag sets", v, 32'h142);
    chk("R9 irq with flag and enable", {31'b0, irq}, 32'h1);
    tick(3);
    peek(5'h08, v); chk("R6 count holds", v, 32'd0);
    peek(5'h00, v);
    wr(5'h00, v);
    peek(5'h00, v); chk("R8 write-back acknowledges", v, 32'h042);
    chk("R8 irq drops after ack", {31'b0, irq}, 32'h0);
    wr(5'h00, 32'h0);
  endtask

  task automatic t_gate_irq;
    logic [31:0] v;
    wr(5'h14, 32'hFFFF_FFFD);
    wr(5'h10, 32'h20);
    wr(5'h10, 32'h80);
    tick(3);
    peek(5'h18, v); chk("R5 up rollover holds all ones", v, 32'hFFFF_FFFF);
    peek(5'h10, v); chk("R5 up rollover flag", v, 32'h100);
    chk("R9 irq masked by enable", {31'b0, irq}, 32'h0);
    wr(5'h10, 32'h40);
    peek(5'h10, v); chk("R8 writing zero keeps flag", v, 32'h140);
    chk("R9 irq on late enable", {31'b0, irq}, 32'h1);
    wr(5'h10, 32'h100);
    peek(5'h10, v); chk("R8 one clears flag", v, 32'h0);
  endtask

  task automatic t_periodic;
    logic [31:0] v;
    wr(5'h04, 32'd2);
    wr(5'h00, 32'h20);
    wr(5'h00, 32'hD2);
    tick(3);
    peek(5'h08, v); chk("R7 reload on rollover", v, 32'd2);
    peek(5'h00, v); chk("R7 run stays set", v, 32'h1D2);
    chk("R9 periodic irq", {31'b0, irq}, 32'h1);
    tick(1);
    peek(5'h08, v); chk("R7 keeps counting", v, 32'd1);
    wr(5'h00, 32'h100);
    chk("R9 irq clear after stop", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    wr(5'h14, 32'hFFFF_FFFE);
    wr(5'h10, 32'h20);
    wr(5'h10, 32'h00);
    wr(5'h14, 32'h0);
    wr(5'h10, 32'h90);
    tick(1);
    peek(5'h18, v); chk("R10 before wrap", v, 32'hFFFF_FFFF);
    tick(1);
    peek(5'h18, v); chk("R10 wraps to zero", v, 32'h0);
    chk("R10 no irq when enable clear", {31'b0, irq}, 32'h0);
    tick(5);
    peek(5'h18, v); chk("R10 free run continues", v, 32'd5);
  endtask

  task automatic t_undefined;
    logic [31:0] v, c;
    wr(5'h10, 32'h100);
    peek(5'h18, c);
    wr(5'h18, 32'h0000_ABCD);
    peek(5'h18, v); chk("R11 counter ignores writes", v, c);
    wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    wr(5'h06, 32'hFFFF_FFFF);
    peek(5'h0C, v); chk("R11 offset 0x0C reads zero", v, 32'h0);
    peek(5'h1C, v); chk("R11 offset 0x1C reads zero", v, 32'h0);
    peek(5'h06, v); chk("R11 unaligned reads zero", v, 32'h0);
    tick(1);
    peek(5'h04, v); chk("R11 reload 0 untouched", v, 32'd2);
    peek(5'h14, v); chk("R11 reload 1 untouched", v, 32'h0);
    peek(5'h10, v); chk("R11 control 1 untouched", v, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick(4);
    t_reset();
    t_probe();
    t_preload();
    t_oneshot_down();
    t_gate_irq();
    t_periodic();
    t_wrap();
    t_undefined();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule